// File: doc/BRIEF.md
# Single-Bus Datapath with Hardwired Step Sequencer

This block is a small processor core in which every register transfer travels over one shared internal bus. It holds a program counter, a memory address register, a memory data register, an instruction register, four general registers and the scratch registers Y and Z. The ALU takes its A operand from a two-way selector, which picks either Y or the word-size constant 4. Its B operand is the bus, and its result can only be written into Z. Each register has its own bus-load and bus-drive enables.

A hardwired sequencer steps through T1..T7. Each control line is an OR of step-and-opcode products. A step that waits for memory holds the counter until the memory reports that the access has completed. The block fetches an instruction, adds a register, adds a memory word addressed by a register, branches unconditionally, and branches when the last register result was negative.

Instruction words split into four fields. The opcode is in bits [31:28]. The source register index is in [27:26] and the destination register index is in [25:24]. A signed byte offset fills [23:0]. Memory is byte addressed and read one word at a time through a request/complete handshake.

Top module: `sbus_core`

## Requirements
- R1: After reset the step counter reads 1 (T1), `mem_rd` is low, `instr_end` is low and the program counter is 0, so the first fetch reads address 0.
- R2: Every instruction begins with a three-step fetch: T1 issues a read at the PC and forms PC+4 in Z; T2 copies Z into PC and Y; T3 copies the returned word into the instruction register. The next fetch is at PC+4 unless a branch is taken. The cycle after an instruction's last step is T1. Fields: opcode [31:28], source index [27:26], destination index [25:24], signed offset [23:0].
- R3: A read request stays raised until the completion signal arrives. A step that waits for memory (T2 always, and T5 of a memory add) holds the counter until the completion has been seen. As a result, a read with a completion delay of d cycles lengthens its instruction by d-1 cycles over the no-wait count.
- R4: Opcode 1 (register add) sets Rdst to Rdst + Rsrc. It ends at T6, and the sum is on the bus in that step.
- R5: Opcode 2 (memory add) reads the word at the byte address held in Rsrc and sets Rdst to Rdst + that word. It ends at T7, and the sum is on the bus in that step.
- R6: Opcode 3 (branch) loads PC with the PC of the next instruction plus the sign-extended offset. It ends at T5, and the target is on the bus in that step.
- R7: Opcode 4 (branch if negative) tests the flag N. N is bit 31 of the last value written into a general register. When N is clear the instruction ends at T4 and the next fetch is at PC+4. When N is set it behaves as opcode 3.
- R8: While `run` is low the step counter and all registers under step control hold. A memory completion that arrives while `run` is low is still captured, and the waiting step then advances as soon as `run` returns high.
- R9: At most one source drives the internal bus in any step.
- R10: Any other opcode (for example 0) ends at T4 without touching a general register or the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High lets the step counter advance; low freezes it |
| mem_addr | output | 32 | Byte address of the read (address register) |
| mem_rd | output | 1 | Read request, held until completion |
| mem_rdata | input | 32 | Read data, valid with `mem_mfc` |
| mem_mfc | input | 1 | One-cycle memory completion pulse |
| bus_mon | output | 32 | Value on the internal bus this cycle |
| step_num | output | 3 | Current step, 1 = T1 .. 7 = T7 |
| instr_end | output | 1 | High in the last step of an instruction |

## Verification
Two things can fall in the same cycle: the memory completion pulse, and the processor having stopped. The processor stops either because `run` is low or because it sits in a waiting step. The bench drops `run` in the first cycle of T2 and uses a three-cycle memory, so the completion arrives while the counter is frozen. It then judges that the step number held at 2, that the request dropped, and that after `run` returns the register add runs to T6 in exactly five more cycles with the correct sum. Completion delays of 1, 2 and 4 are also used so that the completion coincides with the waiting step itself.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    localparam int OP_W      = 4;
    localparam int LAST_STEP = 7;
    localparam int STEP_W    = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_ADDR = 4'd1,
        OP_ADDM = 4'd2,
        OP_BR   = 4'd3,
        OP_BRN  = 4'd4
    } op_e;

    // one bit per gating line of the datapath
    typedef struct packed {
        logic pc_out;
        logic pc_in;
        logic mar_in;
        logic rd;
        logic mdr_out;
        logic ir_in;
        logic y_in;
        logic sel4;
        logic alu_add;
        logic z_in;
        logic z_out;
        logic off_out;
        logic src_out;
        logic dst_out;
        logic dst_in;
        logic wmfc;
        logic fin;
    } ctrl_t;

    function automatic op_e decode_op(input logic [OP_W-1:0] v);
        case (v)
            4'd1:    return OP_ADDR;
            4'd2:    return OP_ADDM;
            4'd3:    return OP_BR;
            4'd4:    return OP_BRN;
            default: return OP_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sbus_seq.sv
module sbus_seq
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  op_e               op,
    input  logic              neg,
    input  logic              mem_ready,
    output ctrl_t             ctl,
    output logic [STEP_W-1:0] step
);

    logic [LAST_STEP:1] t;
    ctrl_t raw;
    logic is_rr, is_rm, is_br, is_bn, is_nop, taken, stall;

    for (genvar i = 1; i <= LAST_STEP; i++) begin : g_step
        assign t[i] = (step == STEP_W'(i));
    end

    always_comb begin
        is_rr  = (op == OP_ADDR);
        is_rm  = (op == OP_ADDM);
        is_br  = (op == OP_BR);
        is_bn  = (op == OP_BRN);
        is_nop = !(is_rr || is_rm || is_br || is_bn);
        taken  = is_br || (is_bn && neg);

        raw         = '0;
        raw.pc_out  = t[1];
        raw.sel4    = t[1];
        raw.mar_in  = t[1] | (t[4] & is_rm);
        raw.rd      = t[1] | (t[4] & is_rm);
        raw.alu_add = t[1] | (t[5] & is_rr) | (t[6] & is_rm) | (t[4] & taken);
        raw.z_in    = t[1] | (t[5] & is_rr) | (t[6] & is_rm) | (t[4] & taken);
        raw.z_out   = t[2] | (t[6] & is_rr) | (t[7] & is_rm) | (t[5] & taken);
        raw.pc_in   = t[2] | (t[5] & taken);
        raw.y_in    = t[2] | (t[4] & is_rr) | (t[5] & is_rm);
        raw.wmfc    = t[2] | (t[5] & is_rm);
        raw.mdr_out = t[3] | (t[6] & is_rm);
        raw.ir_in   = t[3];
        raw.src_out = t[4] & (is_rr | is_rm);
        raw.dst_out = t[5] & (is_rr | is_rm);
        raw.dst_in  = (t[6] & is_rr) | (t[7] & is_rm);
        raw.off_out = t[4] & taken;
        raw.fin     = (t[6] & is_rr) | (t[7] & is_rm) | (t[5] & taken)
                    | (t[4] & is_bn & ~neg) | (t[4] & is_nop);
    end

    assign ctl   = run ? raw : '0;
    assign stall = ctl.wmfc & ~mem_ready;

    always_ff @(posedge clk) begin
        if (rst)
            step <= STEP_W'(1);
        else if (run) begin
            if (ctl.fin)
                step <= STEP_W'(1);
            else if (!stall)
                step <= step + STEP_W'(1);
        end
    end

endmodule

// File: rtl/sbus_alu.sv
module sbus_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] y,
    input  logic [W-1:0] b,
    input  logic         sel4,
    input  logic         add,
    output logic [W-1:0] res
);

    localparam logic [W-1:0] WORD_BYTES = W'(W / 8);

    logic [W-1:0] a;

    assign a   = sel4 ? WORD_BYTES : y;
    assign res = add ? (a + b) : b;

endmodule

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int  W    = 32,
    parameter int  NREG = 4,
    localparam int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] src_idx,
    input  logic [IW-1:0] dst_idx,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  src_val,
    output logic [W-1:0]  dst_val
);

    logic [W-1:0] rd_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr_en && dst_idx == IW'(g))
                q <= wdata;
        end
        assign rd_arr[g] = q;
    end

    assign src_val = rd_arr[src_idx];
    assign dst_val = rd_arr[dst_idx];

endmodule

// File: rtl/sbus_core.sv
module sbus_core
    import sbus_pkg::*;
#(
    parameter int W    = 32,
    parameter int NREG = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    output logic [W-1:0]      mem_addr,
    output logic              mem_rd,
    input  logic [W-1:0]      mem_rdata,
    input  logic              mem_mfc,
    output logic [W-1:0]      bus_mon,
    output logic [STEP_W-1:0] step_num,
    output logic              instr_end
);

    localparam int IW    = $clog2(NREG);
    localparam int OFF_W = W - OP_W - 2 * IW;

    logic [W-1:0] pc_q, mar_q, mdr_q, ir_q, y_q, z_q;
    logic [W-1:0] bus, alu_res, src_val, dst_val, off_ext;
    logic         neg_q, rd_pend, data_ready, mem_ready, mem_take;
    logic [IW-1:0] src_idx, dst_idx;
    op_e          op;
    ctrl_t        ctl;

    assign op      = decode_op(ir_q[W-1 -: OP_W]);
    assign src_idx = ir_q[W-OP_W-1 -: IW];
    assign dst_idx = ir_q[W-OP_W-IW-1 -: IW];
    assign off_ext = {{(W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};

    assign mem_take  = rd_pend & mem_mfc;
    assign mem_ready = data_ready | mem_take;

    sbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .op        (op),
        .neg       (neg_q),
        .mem_ready (mem_ready),
        .ctl       (ctl),
        .step      (step_num)
    );

    sbus_regfile #(.W(W), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .src_idx (src_idx),
        .dst_idx (dst_idx),
        .wr_en   (ctl.dst_in),
        .wdata   (bus),
        .src_val (src_val),
        .dst_val (dst_val)
    );

    sbus_alu #(.W(W)) u_alu (
        .y    (y_q),
        .b    (bus),
        .sel4 (ctl.sel4),
        .add  (ctl.alu_add),
        .res  (alu_res)
    );

    // drive enables are mutually exclusive, so an OR forms the bus
    always_comb begin
        bus = '0;
        if (ctl.pc_out)  bus = bus | pc_q;
        if (ctl.mdr_out) bus = bus | mdr_q;
        if (ctl.z_out)   bus = bus | z_q;
        if (ctl.off_out) bus = bus | off_ext;
        if (ctl.src_out) bus = bus | src_val;
        if (ctl.dst_out) bus = bus | dst_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            mdr_q <= '0;
            ir_q  <= '0;
            y_q   <= '0;
            z_q   <= '0;
            neg_q <= 1'b0;
        end else begin
            if (ctl.pc_in)  pc_q  <= bus;
            if (ctl.mar_in) mar_q <= bus;
            if (mem_take)   mdr_q <= mem_rdata;
            if (ctl.ir_in)  ir_q  <= bus;
            if (ctl.y_in)   y_q   <= bus;
            if (ctl.z_in)   z_q   <= alu_res;
            if (ctl.dst_in) neg_q <= bus[W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend    <= 1'b0;
            data_ready <= 1'b0;
        end else begin
            if (mem_take)
                rd_pend <= 1'b0;
            else if (ctl.rd)
                rd_pend <= 1'b1;

            if (ctl.wmfc && mem_ready)
                data_ready <= 1'b0;
            else if (mem_take)
                data_ready <= 1'b1;
        end
    end

    assign mem_addr  = mar_q;
    assign mem_rd    = rd_pend;
    assign bus_mon   = bus;
    assign instr_end = ctl.fin;

endmodule

// File: rtl/sbus_core_chk.sv
module sbus_core_chk
    import sbus_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              run,
    input ctrl_t             ctl,
    input logic [STEP_W-1:0] step,
    input logic              mem_rd,
    input logic              mem_mfc,
    input logic              instr_end,
    input logic              mem_ready,
    input logic [W-1:0]      pc_q
);

    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.pc_out, ctl.mdr_out, ctl.z_out, ctl.off_out, ctl.src_out, ctl.dst_out})); // R9

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && ctl.wmfc && !mem_ready) |=> $stable(step)); // R3

    AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mem_mfc) |=> mem_rd); // R3

    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(step) && $stable(pc_q))); // R8

    AST_END_RESTART: assert property (@(posedge clk) disable iff (rst)
        (run && instr_end) |=> (step == STEP_W'(1))); // R2

    AST_END_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst)
        instr_end |-> (step >= STEP_W'(4))); // R10

endmodule

bind sbus_core sbus_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .ctl       (ctl),
    .step      (step_num),
    .mem_rd    (mem_rd),
    .mem_mfc   (mem_mfc),
    .instr_end (instr_end),
    .mem_ready (mem_ready),
    .pc_q      (pc_q)
);

// File: tb/sbus_core_test.sv
module sbus_core_test;

    logic        clk, rst, run, mem_mfc;
    logic [31:0] mem_rdata, mem_addr, bus_mon;
    logic        mem_rd, instr_end;
    logic [2:0]  step_num;

    logic [31:0] mem [0:63];
    int          mem_delay;
    int          checks, errors;
    logic        busy;
    int          cnt;
    logic [31:0] lat_addr;

    sbus_core uut (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata),
        .mem_mfc   (mem_mfc),
        .bus_mon   (bus_mon),
        .step_num  (step_num),
        .instr_end (instr_end)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    // memory model: answers a read after mem_delay cycles
    initial begin
        mem_mfc = 1'b0; mem_rdata = '0; busy = 1'b0; cnt = 0; lat_addr = '0;
        forever begin
            @(negedge clk);
            if (mem_mfc) begin
                mem_mfc = 1'b0;
                busy    = 1'b0;
            end else if (busy) begin
                cnt = cnt + 1;
                if (cnt >= mem_delay) begin
                    mem_mfc = 1'b1; mem_rdata = mem[lat_addr[7:2]];
                end
            end else if (mem_rd) begin
                busy = 1'b1; cnt = 1; lat_addr = mem_addr;
                if (cnt >= mem_delay) begin
                    mem_mfc = 1'b1; mem_rdata = mem[lat_addr[7:2]];
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // runs one instruction from its T1 cycle; leaves the bench at the next T1
    task automatic next_instr(output logic [31:0] fa, output logic [2:0] st,
                              output logic [31:0] bv, output int cyc);
        logic seen;
        seen = 1'b0; fa = '1; cyc = 0; st = '0; bv = '0;
        while (1) begin
            cyc = cyc + 1;
            if (mem_rd && !seen) begin
                seen = 1'b1; fa = mem_addr;
            end
            if (instr_end) begin
                st = step_num; bv = bus_mon;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic run_one(input string req, input int dly, input logic [31:0] exp_fa,
                           input logic [2:0] exp_st, input bit chk_bus,
                           input logic [31:0] exp_bus, input int exp_cyc);
        logic [31:0] fa, bv;
        logic [2:0]  st;
        int          cyc;
        mem_delay = dly;
        next_instr(fa, st, bv, cyc);
        chk(req, "fetch address", fa, exp_fa);
        chk(req, "end step", {29'd0, st}, {29'd0, exp_st});
        if (chk_bus) chk(req, "bus at end", bv, exp_bus);
        chk("R3", "instruction cycles", cyc, exp_cyc);
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "step after reset", {29'd0, step_num}, 32'd1);
        chk("R1", "mem_rd after reset", {31'd0, mem_rd}, 32'd0);
        chk("R1", "instr_end after reset", {31'd0, instr_end}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R8", "step held with run low", {29'd0, step_num}, 32'd1);
        chk("R8", "no read with run low", {31'd0, mem_rd}, 32'd0);
        run = 1'b1;
    endtask

    // R5: memory add, R1 <- R1 + mem[R0]; first fetch at 0 (R1)
    task automatic t_mem_add_first();
        run_one("R5", 1, 32'h0000_0000, 3'd7, 1'b1, 32'h2100_0040, 7);
    endtask

    // R5 with pointer register; fetch at 4 shows PC+4 (R2)
    task automatic t_mem_add_ptr();
        run_one("R2", 2, 32'h0000_0004, 3'd7, 1'b1, 32'h8000_0005, 9);
    endtask

    task automatic t_reg_add();
        run_one("R4", 2, 32'h0000_0008, 3'd6, 1'b1, 32'hA100_0045, 7);
    endtask

    task automatic t_brn_taken();
        run_one("R7", 2, 32'h0000_000C, 3'd5, 1'b1, 32'h0000_0018, 6);
    endtask

    // R8: completion arrives while run is low
    task automatic t_freeze();
        logic [31:0] fa, bv;
        logic [2:0]  st;
        int          cyc;
        mem_delay = 3;
        @(negedge clk);
        chk("R7", "taken target fetched", mem_addr, 32'h0000_0018);
        chk("R2", "read raised in T2", {31'd0, mem_rd}, 32'd1);
        run = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8", "step frozen at T2", {29'd0, step_num}, 32'd2);
        end
        chk("R8", "read completed while frozen", {31'd0, mem_rd}, 32'd0);
        run = 1'b1;
        next_instr(fa, st, bv, cyc);
        chk("R8", "cycles after resume", cyc, 5);
        chk("R4", "end step after resume", {29'd0, st}, 32'd6);
        chk("R4", "sum after resume", bv, 32'h2100_0040);
    endtask

    task automatic t_brn_not_taken();
        run_one("R7", 1, 32'h0000_001C, 3'd4, 1'b0, 32'h0, 4);
    endtask

    // fetch at 0x20 proves the not-taken fall-through (R7)
    task automatic t_other_op();
        run_one("R10", 1, 32'h0000_0020, 3'd4, 1'b0, 32'h0, 4);
    endtask

    task automatic t_branch();
        run_one("R6", 4, 32'h0000_0024, 3'd5, 1'b1, 32'h0000_0000, 8);
    endtask

    // back at 0 after the branch (R6); R1 kept its value across instructions
    task automatic t_wrap();
        run_one("R6", 2, 32'h0000_0000, 3'd7, 1'b1, 32'h4200_0080, 9);
    endtask

    initial begin
        checks = 0; errors = 0; mem_delay = 1;
        rst = 1'b1; run = 1'b0;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[0]  = 32'h2100_0040; // memory add R1 += [R0]
        mem[1]  = 32'h2600_0000; // memory add R2 += [R1]
        mem[2]  = 32'h1600_0000; // register add R2 += R1
        mem[3]  = 32'h4000_0008; // branch if negative +8
        mem[6]  = 32'h1700_0000; // register add R3 += R1
        mem[7]  = 32'h4000_0020; // branch if negative +0x20
        mem[8]  = 32'h0000_0000; // other opcode
        mem[9]  = 32'h30FF_FFD8; // branch -0x28
        mem[16] = 32'h8000_0005; // data word

        t_reset();
        t_mem_add_first();
        t_mem_add_ptr();
        t_reg_add();
        t_brn_taken();
        t_freeze();
        t_brn_not_taken();
        t_other_op();
        t_branch();
        t_wrap();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule